// File: doc/BRIEF.md
# Match Timer with Watchdog Reset Request

This block is a register-mapped timer built around one free-running 32-bit up-counter. The counter advances by one at each clock edge where the tick-enable input is high; in a system that input pulses once per microsecond. Six compare channels each hold a 32-bit target. When the counter steps onto a channel's target, that channel's sticky status flag is set. An interrupt line for the channel is raised while the flag and the channel's enable bit are both set.

Channel 5 also serves as a watchdog. A reset request fires only when the global watchdog arm bit and channel 5's interrupt enable are both set at the moment the counter reaches channel 5's target. Once raised, the request holds until the block itself is reset. Software keeps the watchdog from firing by snapshotting the counter through a capture register, adding its timeout in ticks, and writing the sum back as channel 5's target. The time left is that target minus the live count.

The register bus is a plain single-cycle port with address, write enable, write data and combinational read data. Register offsets: counter 0x00; compare channel n at 0x08 + 4·n, so channel 5 is at 0x1C; status at 0x20; interrupt enable at 0x24; watchdog arm at 0x28; capture strobe at 0x30; captured value at 0x34.

Top module: `match_timer_wdog`

## Requirements
- R1: After reset the counter, every compare target, the status flags, the interrupt enables, the watchdog arm bit and the captured value all read zero. `irq` is 0 and `rstReq` is 0, including after a reset that follows a raised request.
- R2: The counter (read at 0x00) increments by one on each clock edge where `tickEn` is 1 and holds its value on every other edge.
- R3: Compare channel n is read and written at offset 0x08 + 4·n, and it reads back the full 32-bit value last written.
- R4: When an increment makes the counter equal to channel n's target, status bit n (offset 0x20) becomes 1 and stays 1. Writing to 0x20 clears exactly the bits written as 1; bits written as 0 are unaffected.
- R5: The interrupt enable register at 0x24 holds bit n for channel n; only bits 5:0 are stored. `irq[n]` is 1 exactly when status bit n and enable bit n are both 1.
- R6: Bit 0 of the register at 0x28 is the watchdog arm bit: writing 1 arms, writing 0 disarms, and a read returns its state.
- R7: When the counter steps onto channel 5's target while the arm bit and enable bit 5 are both 1, `rstReq` rises on that edge and stays 1 until reset, whatever is written afterwards. Rewriting channel 5's target before the counter reaches it prevents the request.
- R8: If either the arm bit or enable bit 5 is 0 when channel 5 matches, `rstReq` stays 0. Status bit 5 is still set.
- R9: A write with bit 0 = 1 to 0x30 copies the counter value present at that edge into the captured register (read at 0x34). Later counting does not change it. A write to 0x30 with bit 0 = 0 has no effect.
- R10: Reads of offsets outside the map, and of 0x30, return zero. Writes to such offsets, and to the counter at 0x00, change no readable state.
- R11: If a match on channel n and a write-1-clear of status bit n land on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Counter advance enable (one pulse per microsecond) |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write enable, acted on at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irq | output | 6 | Per-channel interrupt, status AND enable |
| rstReq | output | 1 | Sticky watchdog reset request |

## Verification
Read data depends only on the address and the stored state, so a read is due in the same cycle its address is driven. The bench samples it at the falling edge of that cycle. Counter, status, capture and reset-request changes land on the edge that carries the tick or the write, so they are due one edge after the stimulus; the `irq` output follows status combinationally in that same cycle. The driver changes inputs just after a rising edge and queues each expected value with its kind. The monitor pops and compares at the next falling edge, so every comparison falls exactly one half-cycle after the edge that should have produced the value.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  localparam int NUM_CH  = 6;
  localparam int WDOG_CH = 5;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h00;
  localparam int                OFS_MATCH0 = 8;
  localparam int                MATCH_STEP = 4;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_WDOG   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LATCH  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SNAP   = 8'h34;

  // strobes from control to datapath
  typedef struct packed {
    logic              latchStb;
    logic [NUM_CH-1:0] matchWr;
  } dpStrobes_t;

  function automatic logic [ADDR_W-1:0] matchOfs(input int n);
    return ADDR_W'(OFS_MATCH0 + MATCH_STEP * n);
  endfunction
endpackage

// File: rtl/mtw_match_chan.sv
module mtw_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] cntNext,
  output logic [CNT_W-1:0] matchVal,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst)       matchVal <= '0;
    else if (wrEn) matchVal <= wrData;
  end

  // equality on the value the counter steps onto; wraps modulo 2^CNT_W
  assign hit = tickEn && (cntNext == matchVal);

  p_target_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(matchVal));
endmodule

// File: rtl/mtw_datapath.sv
module mtw_datapath
  import mtw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  dpStrobes_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [NUM_CH-1:0] matchHit,
  output logic [CNT_W-1:0]  dpRdData
);
  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] snapReg;
  logic [CNT_W-1:0] matchVal [NUM_CH];
  logic [NUM_CH-1:0] matchRdSel;

  assign cntNext = cntReg + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         cntReg <= '0;
    else if (tickEn) cntReg <= cntNext;
  end

  always_ff @(posedge clk) begin
    if (rst)                snapReg <= '0;
    else if (strb.latchStb) snapReg <= cntReg;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    mtw_match_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wrEn     (strb.matchWr[n]),
      .wrData   (busWrData),
      .tickEn   (tickEn),
      .cntNext  (cntNext),
      .matchVal (matchVal[n]),
      .hit      (matchHit[n])
    );
    assign matchRdSel[n] = (busAddr == matchOfs(n));
  end

  always_comb begin
    dpRdData = '0;
    if (busAddr == OFS_COUNT) dpRdData = cntReg;
    if (busAddr == OFS_SNAP)  dpRdData = snapReg;
    for (int n = 0; n < NUM_CH; n++) begin
      if (matchRdSel[n]) dpRdData = matchVal[n];
    end
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> cntReg == $past(cntReg) + CNT_W'(1));
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(cntReg));
  p_snap_take_r9: assert property (@(posedge clk) disable iff (rst)
    strb.latchStb |=> snapReg == $past(cntReg));
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.latchStb |=> $stable(snapReg));
endmodule

// File: rtl/mtw_ctrl.sv
module mtw_ctrl
  import mtw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NUM_CH-1:0] wrBits,
  input  logic [NUM_CH-1:0] matchHit,
  output dpStrobes_t        strb,
  output logic [NUM_CH-1:0] irq,
  output logic              rstReq,
  output logic [CNT_W-1:0]  ctrlRdData
);
  logic [NUM_CH-1:0] statusReg;
  logic [NUM_CH-1:0] ienReg;
  logic              wdogArm;
  logic              statusWr;
  logic [NUM_CH-1:0] statusClr;
  logic              wdogFire;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_wdec
    assign strb.matchWr[n] = busWe && (busAddr == matchOfs(n));
  end
  assign strb.latchStb = busWe && (busAddr == OFS_LATCH) && wrBits[0];

  assign statusWr  = busWe && (busAddr == OFS_STATUS);
  assign statusClr = statusWr ? wrBits : '0;

  always_ff @(posedge clk) begin
    if (rst) statusReg <= '0;
    else     statusReg <= (statusReg & ~statusClr) | matchHit;  // set wins
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ienReg  <= '0;
      wdogArm <= 1'b0;
    end else if (busWe) begin
      if (busAddr == OFS_IEN)  ienReg  <= wrBits;
      if (busAddr == OFS_WDOG) wdogArm <= wrBits[0];
    end
  end

  assign wdogFire = matchHit[WDOG_CH] && wdogArm && ienReg[WDOG_CH];

  always_ff @(posedge clk) begin
    if (rst)           rstReq <= 1'b0;
    else if (wdogFire) rstReq <= 1'b1;
  end

  assign irq = statusReg & ienReg;

  always_comb begin
    ctrlRdData = '0;
    if (busAddr == OFS_STATUS) ctrlRdData = CNT_W'(statusReg);
    if (busAddr == OFS_IEN)    ctrlRdData = CNT_W'(ienReg);
    if (busAddr == OFS_WDOG)   ctrlRdData = CNT_W'(wdogArm);
  end

  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    rstReq |=> rstReq);
  p_req_cause_r7: assert property (@(posedge clk) disable iff (rst)
    !rstReq && matchHit[WDOG_CH] && wdogArm && ienReg[WDOG_CH] |=> rstReq);
  p_req_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (!wdogArm || !ienReg[WDOG_CH]) && !rstReq |=> !rstReq);
  p_status_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !statusWr |=> (statusReg & $past(statusReg)) == $past(statusReg));
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    matchHit != '0 |=> (statusReg & $past(matchHit)) == $past(matchHit));
endmodule

// File: rtl/match_timer_wdog.sv
module match_timer_wdog
  import mtw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] irq,
  output logic              rstReq
);
  dpStrobes_t        strb;
  logic [NUM_CH-1:0] matchHit;
  logic [CNT_W-1:0]  dpRdData;
  logic [CNT_W-1:0]  ctrlRdData;

  mtw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .wrBits     (busWrData[NUM_CH-1:0]),
    .matchHit   (matchHit),
    .strb       (strb),
    .irq        (irq),
    .rstReq     (rstReq),
    .ctrlRdData (ctrlRdData)
  );

  mtw_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .tickEn    (tickEn),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .matchHit  (matchHit),
    .dpRdData  (dpRdData)
  );

  // the two halves decode disjoint offsets, each returns zero elsewhere
  assign busRdData = dpRdData | ctrlRdData;
endmodule

// File: tb/match_timer_wdog_bench.sv
module match_timer_wdog_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  irq;
  logic        rstReq;

  int checks = 0;
  int errors = 0;
  int mCnt = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 reset request
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  match_timer_wdog u_match_timer_wdog (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq), .rstReq(rstReq)
  );

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = (it.kind == 0) ? busRdData : (it.kind == 1) ? 32'(irq) : 32'(rstReq);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWe = 1'b1;
    step();
    busWe = 1'b0; busWrData = '0;
  endtask

  task automatic tick(input int n);
    tickEn = 1'b1;
    repeat (n) step();
    tickEn = 1'b0;
    mCnt += n;
  endtask

  task automatic tickWr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWe = 1'b1; tickEn = 1'b1;
    step();
    busWe = 1'b0; tickEn = 1'b0; busWrData = '0;
    mCnt += 1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    busAddr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    step();
  endtask

  task automatic chk(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    step();
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    mCnt = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    rd(8'h00, 0, "R1 counter");
    rd(8'h1C, 0, "R1 target5");
    rd(8'h20, 0, "R1 status");
    rd(8'h24, 0, "R1 enable");
    rd(8'h28, 0, "R1 arm");
    rd(8'h34, 0, "R1 capture");
    chk(1, 0, "R1 irq");
    chk(2, 0, "R1 rstReq");

    // R2 counting and holding
    tick(10);
    rd(8'h00, 32'(mCnt), "R2 count10");
    step(); step();
    rd(8'h00, 32'(mCnt), "R2 hold");

    // R3 targets
    wr(8'h08, 20);
    wr(8'h0C, 15);
    wr(8'h1C, 32'hDEAD_0001);
    rd(8'h08, 20, "R3 ch0");
    rd(8'h0C, 15, "R3 ch1");
    rd(8'h1C, 32'hDEAD_0001, "R3 ch5");

    // R5 enable register keeps low six bits
    wr(8'h24, 32'hFFFF_FFC3);
    rd(8'h24, 32'h03, "R5 enable readback");

    // R4 matches set sticky flags
    tick(5);
    rd(8'h20, 32'h02, "R4 ch1 hit");
    chk(1, 32'h02, "R5 irq ch1");
    tick(5);
    rd(8'h20, 32'h03, "R4 ch0 hit");
    chk(1, 32'h03, "R5 irq both");
    tick(3);
    rd(8'h20, 32'h03, "R4 sticky");
    wr(8'h20, 0);
    rd(8'h20, 32'h03, "R4 zero write");
    wr(8'h20, 1);
    rd(8'h20, 32'h02, "R4 clear bit0");
    wr(8'h24, 1);
    chk(1, 0, "R5 masked");
    rd(8'h20, 32'h02, "R5 status kept");

    // R9 capture
    wr(8'h30, 1);
    rd(8'h34, 32'(mCnt), "R9 captured");
    tick(4);
    rd(8'h34, 32'(mCnt - 4), "R9 held");
    rd(8'h00, 32'(mCnt), "R2 count27");
    wr(8'h30, 2);
    rd(8'h34, 32'(mCnt - 4), "R9 bit0 zero");

    // R10 unmapped and read-only
    wr(8'h04, 32'hFFFF);
    rd(8'h04, 0, "R10 unmapped");
    wr(8'h00, 5);
    rd(8'h00, 32'(mCnt), "R10 counter write");
    rd(8'h3C, 0, "R10 high offset");
    rd(8'h30, 0, "R10 strobe reads zero");

    // R8 armed but channel enable clear
    wr(8'h28, 1);
    rd(8'h28, 1, "R6 arm set");
    wr(8'h1C, 30);
    wr(8'h24, 0);
    tick(3);
    rd(8'h20, 32'h22, "R8 status5 set");
    chk(2, 0, "R8 no req enable clear");

    // R8 enable set but disarmed
    wr(8'h20, 32'h3F);
    rd(8'h20, 0, "R4 clear all");
    wr(8'h28, 0);
    rd(8'h28, 0, "R6 arm clear");
    wr(8'h24, 32'h20);
    wr(8'h1C, 35);
    tick(5);
    chk(2, 0, "R8 no req disarmed");
    chk(1, 32'h20, "R5 irq ch5");

    // R11 set wins over same-edge clear
    wr(8'h10, 36);
    tickWr(8'h20, 32'h24);
    rd(8'h20, 32'h04, "R11 set wins");

    // R7 refresh then fire
    wr(8'h28, 1);
    wr(8'h1C, 40);
    tick(3);
    chk(2, 0, "R7 before target");
    wr(8'h30, 1);
    rd(8'h34, 39, "R7 snapshot");
    wr(8'h1C, 39 + 3);
    tick(1);
    chk(2, 0, "R7 refreshed");
    tick(1);
    chk(2, 0, "R7 one left");
    tick(1);
    chk(2, 1, "R7 fired");
    wr(8'h28, 0);
    wr(8'h24, 0);
    tick(2);
    chk(2, 1, "R7 held");

    doReset();
    chk(2, 0, "R1 req cleared");
    rd(8'h00, 0, "R1 counter after");

    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule